// File: doc/BRIEF.md
# Single-Line Instruction Fetch Buffer

This block sits between a 32-bit stack processor and two memories: a small on-chip RAM that covers the lowest 64 KB of the address space, and a large external memory behind a controller. The controller always moves a whole 16-byte line per access and takes around twenty cycles to deliver it. Instructions are 16 bits wide and each read returns a 32-bit word, so straight-line code reads every word twice. Without buffering, each of those reads pays the full controller latency.

The block keeps the one line brought in by the most recent instruction-fetch miss to external memory. A later fetch to the same 16-byte segment is answered from that line in the cycle it is presented, with no memory traffic. The processor marks each request as a fetch or a data access, and only fetches are served from or loaded into the line. Data reads and writes to external memory always go to the controller. A write that lands in the buffered segment invalidates the line. Every access to the low 64 KB goes to the on-chip RAM and never touches the line.

The processor holds a request (read or write strobe, address, fetch flag, write data) until it sees `cpu_ready` high for one cycle. It then drops the request or presents the next one.

Top module: `ifetch_line_buf`

## Requirements
- R1: After reset the line is invalid: `cpu_ready`, `mem_req` and `sram_en` are low while no request is present, and the first fetch to external memory makes one controller access.
- R2: On a miss, `mem_addr` carries the request address with bits [3:0] cleared and is held until `mem_ack`. `cpu_ready` rises in the `mem_ack` cycle, carrying the word of `mem_rline` chosen by address bits [3:2], where word k sits in bits [32k+31:32k].
- R3: A fetch whose address bits [31:4] match a valid line is answered with `cpu_ready` in the cycle it is presented, with the correct word and no controller access.
- R4: Eight consecutive 16-bit fetches covering byte offsets 0, 2, ... 14 of one cold line cause exactly one controller access.
- R5: A fetch to another external segment misses and replaces the line. Returning to the earlier segment then misses again.
- R6: A data read (`cpu_ifetch` low) to external memory always goes to the controller, even inside the buffered segment, and leaves the line intact.
- R7: Any access with address bits [31:16] all zero goes to the on-chip RAM (`sram_addr` = address bits [15:2]). `cpu_ready` comes one cycle after `sram_en`, no controller request is made, and the line is left intact.
- R8: A write inside the buffered segment invalidates the line, so the next fetch there misses and returns the newly written word.
- R9: A write to a different external segment leaves the line valid.
- R10: While `mem_req` is high and `mem_ack` is low, the request and its address stay unchanged on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_addr | input | 32 | Byte address of the request |
| cpu_rd | input | 1 | Read request, held until ready |
| cpu_wr | input | 1 | Write request, held until ready |
| cpu_ifetch | input | 1 | High when the read is an instruction fetch |
| cpu_wdata | input | 32 | Write data |
| cpu_rdata | output | 32 | Read data, valid while `cpu_ready` is high |
| cpu_ready | output | 1 | One-cycle completion pulse |
| sram_en | output | 1 | On-chip RAM access enable |
| sram_we | output | 1 | On-chip RAM write enable |
| sram_addr | output | 14 | On-chip RAM word address |
| sram_wdata | output | 32 | On-chip RAM write data |
| sram_rdata | input | 32 | On-chip RAM read data, one cycle after enable |
| mem_req | output | 1 | Controller request, held until acknowledge |
| mem_we | output | 1 | Controller request is a word write |
| mem_addr | output | 32 | Line-aligned controller address |
| mem_wsel | output | 2 | Word index within the line for writes |
| mem_wdata | output | 32 | Controller write data |
| mem_ack | input | 1 | Controller completion, one cycle |
| mem_rline | input | 128 | Line returned with `mem_ack` |

## Verification
Two things happen together on a fetch miss. In the acknowledge cycle the line register loads the incoming line while the processor receives a word taken straight off the controller bus. The bench provokes this with a cold fetch at an odd word offset and judges it twice: the returned word must match the model, and the very next fetch in that segment must complete in one cycle with no new controller access. The same check is repeated after a write has invalidated the line. That makes the invalidate and the next fill fall on consecutive accesses of one segment.

// File: rtl/ifb_pkg.sv
package ifb_pkg;

    typedef enum logic [1:0] {
        IFB_IDLE = 2'd0,
        IFB_SRAM = 2'd1,
        IFB_MEM  = 2'd2
    } ifb_state_e;

    typedef struct packed {
        ifb_state_e state;
    } ifb_ctl_s;

endpackage

// File: rtl/ifb_region_decode.sv
module ifb_region_decode #(
    parameter int ADDR_W   = 32,
    parameter int LOW_BITS = 16
) (
    input  logic [ADDR_W-1:LOW_BITS] upper_addr,
    output logic                     is_low
);
    assign is_low = (upper_addr == '0);
endmodule

// File: rtl/ifb_word_pick.sv
module ifb_word_pick #(
    parameter int DATA_W = 32,
    parameter int WORDS  = 4,
    localparam int SEL_W  = $clog2(WORDS),
    localparam int LINE_W = DATA_W * WORDS
) (
    input  logic [LINE_W-1:0] line,
    input  logic [SEL_W-1:0]  sel,
    output logic [DATA_W-1:0] word
);
    logic [DATA_W-1:0] slots [WORDS];

    for (genvar gi = 0; gi < WORDS; gi++) begin : g_slot
        assign slots[gi] = line[gi*DATA_W +: DATA_W];
    end

    assign word = slots[sel];
endmodule

// File: rtl/ifb_line_store.sv
module ifb_line_store #(
    parameter int DATA_W = 32,
    parameter int WORDS  = 4,
    parameter int TAG_W  = 28,
    localparam int SEL_W  = $clog2(WORDS),
    localparam int LINE_W = DATA_W * WORDS
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic              inv,
    input  logic [TAG_W-1:0]  fill_tag,
    input  logic [LINE_W-1:0] fill_line,
    input  logic [TAG_W-1:0]  look_tag,
    input  logic [SEL_W-1:0]  look_sel,
    output logic              hit,
    output logic [DATA_W-1:0] word
);
    typedef struct packed {
        logic              valid;
        logic [TAG_W-1:0]  tag;
        logic [LINE_W-1:0] data;
    } line_s;

    line_s line_d, line_q;

    always_comb begin
        line_d = line_q;
        if (inv) begin
            line_d.valid = 1'b0;
        end
        if (load) begin
            line_d.valid = 1'b1;
            line_d.tag   = fill_tag;
            line_d.data  = fill_line;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            line_q <= '0;
        end else begin
            line_q <= line_d;
        end
    end

    assign hit = line_q.valid && (line_q.tag == look_tag);

    ifb_word_pick #(.DATA_W(DATA_W), .WORDS(WORDS)) u_pick (
        .line (line_q.data),
        .sel  (look_sel),
        .word (word)
    );
endmodule

// File: rtl/ifetch_line_buf.sv
module ifetch_line_buf
    import ifb_pkg::*;
#(
    parameter int ADDR_W   = 32,
    parameter int DATA_W   = 32,
    parameter int WORDS    = 4,
    parameter int LOW_BITS = 16,
    localparam int BYTE_W  = $clog2(DATA_W / 8),
    localparam int SEL_W   = $clog2(WORDS),
    localparam int OFF_W   = BYTE_W + SEL_W,
    localparam int TAG_W   = ADDR_W - OFF_W,
    localparam int LINE_W  = DATA_W * WORDS,
    localparam int SRAM_AW = LOW_BITS - BYTE_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [ADDR_W-1:0]  cpu_addr,
    input  logic               cpu_rd,
    input  logic               cpu_wr,
    input  logic               cpu_ifetch,
    input  logic [DATA_W-1:0]  cpu_wdata,
    output logic [DATA_W-1:0]  cpu_rdata,
    output logic               cpu_ready,
    output logic               sram_en,
    output logic               sram_we,
    output logic [SRAM_AW-1:0] sram_addr,
    output logic [DATA_W-1:0]  sram_wdata,
    input  logic [DATA_W-1:0]  sram_rdata,
    output logic               mem_req,
    output logic               mem_we,
    output logic [ADDR_W-1:0]  mem_addr,
    output logic [SEL_W-1:0]   mem_wsel,
    output logic [DATA_W-1:0]  mem_wdata,
    input  logic               mem_ack,
    input  logic [LINE_W-1:0]  mem_rline
);
    ifb_ctl_s ctl_d, ctl_q;

    logic              is_low;
    logic              line_hit;
    logic [DATA_W-1:0] line_word;
    logic [DATA_W-1:0] bus_word;
    logic              fill_load;
    logic              line_inv;
    logic [TAG_W-1:0]  req_tag;
    logic [SEL_W-1:0]  req_sel;
    logic              cpu_req;
    logic              unused_lsb;

    assign req_tag    = cpu_addr[ADDR_W-1:OFF_W];
    assign req_sel    = cpu_addr[OFF_W-1:BYTE_W];
    assign cpu_req    = cpu_rd || cpu_wr;
    assign unused_lsb = ^cpu_addr[BYTE_W-1:0];

    ifb_region_decode #(.ADDR_W(ADDR_W), .LOW_BITS(LOW_BITS)) u_region (
        .upper_addr (cpu_addr[ADDR_W-1:LOW_BITS]),
        .is_low     (is_low)
    );

    ifb_line_store #(.DATA_W(DATA_W), .WORDS(WORDS), .TAG_W(TAG_W)) u_line (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (fill_load),
        .inv       (line_inv),
        .fill_tag  (req_tag),
        .fill_line (mem_rline),
        .look_tag  (req_tag),
        .look_sel  (req_sel),
        .hit       (line_hit),
        .word      (line_word)
    );

    ifb_word_pick #(.DATA_W(DATA_W), .WORDS(WORDS)) u_bus_pick (
        .line (mem_rline),
        .sel  (req_sel),
        .word (bus_word)
    );

    // Static request fields: the processor holds them until ready.
    assign sram_addr  = cpu_addr[LOW_BITS-1:BYTE_W];
    assign sram_wdata = cpu_wdata;
    assign mem_addr   = {req_tag, {OFF_W{1'b0}}};
    assign mem_wsel   = req_sel;
    assign mem_wdata  = cpu_wdata;
    assign mem_req    = (ctl_q.state == IFB_MEM);
    assign mem_we     = (ctl_q.state == IFB_MEM) && cpu_wr;

    always_comb begin
        ctl_d     = ctl_q;
        cpu_ready = 1'b0;
        cpu_rdata = '0;
        sram_en   = 1'b0;
        sram_we   = 1'b0;
        fill_load = 1'b0;
        line_inv  = 1'b0;
        unique case (ctl_q.state)
            IFB_IDLE: begin
                if (cpu_req) begin
                    if (is_low) begin
                        sram_en     = 1'b1;
                        sram_we     = cpu_wr;
                        ctl_d.state = IFB_SRAM;
                    end else if (cpu_rd && cpu_ifetch && line_hit) begin
                        cpu_ready = 1'b1;
                        cpu_rdata = line_word;
                    end else begin
                        line_inv    = cpu_wr && line_hit;
                        ctl_d.state = IFB_MEM;
                    end
                end
            end
            IFB_SRAM: begin
                cpu_ready   = 1'b1;
                cpu_rdata   = cpu_rd ? sram_rdata : '0;
                ctl_d.state = IFB_IDLE;
            end
            IFB_MEM: begin
                if (mem_ack) begin
                    cpu_ready   = 1'b1;
                    cpu_rdata   = cpu_rd ? bus_word : '0;
                    fill_load   = cpu_rd && cpu_ifetch;
                    ctl_d.state = IFB_IDLE;
                end
            end
            default: ctl_d.state = IFB_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_q <= '{state: IFB_IDLE};
        end else begin
            ctl_q <= ctl_d;
        end
    end
endmodule

// File: rtl/ifetch_line_buf_chk.sv
module ifetch_line_buf_chk #(
    parameter int ADDR_W   = 32,
    parameter int LOW_BITS = 16,
    parameter int OFF_W    = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] cpu_addr,
    input logic              cpu_rd,
    input logic              cpu_wr,
    input logic              cpu_ready,
    input logic              sram_en,
    input logic              mem_req,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              mem_ack
);
    p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_ready |-> (cpu_rd || cpu_wr));

    p_line_aligned_r2: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> (mem_addr[OFF_W-1:0] == '0) &&
                    (mem_addr[ADDR_W-1:OFF_W] == cpu_addr[ADDR_W-1:OFF_W]));

    p_ack_completes_r2: assert property (@(posedge clk) disable iff (!rst_n)
        mem_ack |-> cpu_ready);

    p_low_no_slow_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ((cpu_rd || cpu_wr) && (cpu_addr[ADDR_W-1:LOW_BITS] == '0)) |-> !mem_req);

    p_sram_one_cycle_r7: assert property (@(posedge clk) disable iff (!rst_n)
        sram_en |=> cpu_ready);

    p_req_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr)));
endmodule

bind ifetch_line_buf ifetch_line_buf_chk #(
    .ADDR_W   (ADDR_W),
    .LOW_BITS (LOW_BITS),
    .OFF_W    (OFF_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cpu_addr  (cpu_addr),
    .cpu_rd    (cpu_rd),
    .cpu_wr    (cpu_wr),
    .cpu_ready (cpu_ready),
    .sram_en   (sram_en),
    .mem_req   (mem_req),
    .mem_addr  (mem_addr),
    .mem_ack   (mem_ack)
);

// File: tb/ifetch_line_buf_test.sv
module ifetch_line_buf_test;
    localparam int LAT = 21;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [31:0]  cpu_addr = '0;
    logic         cpu_rd = 1'b0, cpu_wr = 1'b0, cpu_ifetch = 1'b0;
    logic [31:0]  cpu_wdata = '0;
    logic [31:0]  cpu_rdata;
    logic         cpu_ready;
    logic         sram_en, sram_we;
    logic [13:0]  sram_addr;
    logic [31:0]  sram_wdata;
    logic [31:0]  sram_rdata = '0;
    logic         mem_req, mem_we;
    logic [31:0]  mem_addr;
    logic [1:0]   mem_wsel;
    logic [31:0]  mem_wdata;
    logic         mem_ack = 1'b0;
    logic [127:0] mem_rline = '0;

    ifetch_line_buf uut (.*);

    always #10 clk = ~clk;

    int n_checks = 0, n_fail = 0;
    int line_reads = 0;
    int mem_cnt = 0;
    logic [31:0] last_line_addr = '0;
    bit done = 0;

    logic [31:0] slow_st [logic [31:0]];
    logic [31:0] fast_st [logic [13:0]];
    logic [31:0] exp_data [$];
    string       exp_tag [$];

    function automatic logic [31:0] slow_word(input logic [31:0] a);
        if (slow_st.exists(a)) return slow_st[a];
        return a ^ 32'h5A5A_C3C3;
    endfunction

    function automatic logic [31:0] fast_word(input logic [13:0] i);
        if (fast_st.exists(i)) return fast_st[i];
        return {18'h2A5A5, i} ^ 32'h0F0F_0000;
    endfunction

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // On-chip RAM model: one-cycle read latency
    always @(posedge clk) begin
        if (sram_en) begin
            if (sram_we) fast_st[sram_addr] = sram_wdata;
            else sram_rdata <= fast_word(sram_addr);
        end
    end

    // Slow controller model: acknowledge LAT negedges after the request
    always begin
        @(negedge clk);
        if (mem_ack) begin
            mem_ack = 1'b0;
        end else if (mem_req) begin
            mem_cnt++;
            if (mem_cnt == LAT) begin
                mem_cnt = 0;
                last_line_addr = mem_addr;
                if (mem_we) begin
                    slow_st[mem_addr + {28'd0, mem_wsel, 2'b00}] = mem_wdata;
                end else begin
                    line_reads++;
                    for (int k = 0; k < 4; k++)
                        mem_rline[32*k +: 32] = slow_word(mem_addr + 32'(4*k));
                end
                mem_ack = 1'b1;
            end
        end
    end

    // Monitor: compares every completed read with the scoreboard
    always begin
        @(negedge clk);
        #8;
        if (rst_n && cpu_ready && cpu_rd) begin
            if (exp_data.size() == 0) begin
                check(1'b0, "R2 unexpected read", cpu_rdata, 32'h0);
            end else begin
                logic [31:0] e;
                string t;
                e = exp_data.pop_front();
                t = exp_tag.pop_front();
                check(cpu_rdata === e, t, cpu_rdata, e);
            end
        end
    end

    // Driver: pushes expected data, drives one access, returns cycles to ready
    task automatic access(input logic [31:0] a, input bit wr, input bit fetch,
                          input logic [31:0] wd, input string req, output int cycles);
        bit got;
        if (!wr) begin
            exp_data.push_back(a[31:16] == 16'h0 ? fast_word(a[15:2]) : slow_word({a[31:2], 2'b00}));
            exp_tag.push_back(req);
        end
        @(negedge clk);
        cpu_addr = a; cpu_rd = !wr; cpu_wr = wr; cpu_ifetch = fetch; cpu_wdata = wd;
        cycles = 0;
        forever begin
            #8;
            got = cpu_ready;
            cycles++;
            @(negedge clk);
            if (got) break;
        end
        cpu_rd = 1'b0; cpu_wr = 1'b0; cpu_ifetch = 1'b0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_checks++; n_fail++;
        $display("FAIL watchdog expired actual=0 expected=1");
        finish_run();
    end

    initial begin
        int cyc, r0;
        logic [31:0] base_a, base_b;
        base_a = 32'h0002_0040;
        base_b = 32'h0002_0100;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk); #8;
        check(!cpu_ready && !mem_req && !sram_en, "R1 reset quiet",
              {29'd0, cpu_ready, mem_req, sram_en}, 32'd0);

        // R1/R2: cold fetch at word 1 misses; line-aligned request
        r0 = line_reads;
        access(base_a + 32'd6, 0, 1, '0, "R2 miss word", cyc);
        check(line_reads == r0 + 1, "R1 first fetch misses", line_reads - r0, 1);
        check(last_line_addr == base_a, "R2 line address", last_line_addr, base_a);
        check(cyc > LAT, "R2 miss latency", cyc, LAT + 1);
        // R3: fill-cycle result is usable next access
        access(base_a + 32'd12, 0, 1, '0, "R3 hit after fill", cyc);
        check(cyc == 1, "R3 hit zero wait", cyc, 1);

        // R4: eight 16-bit fetches in a cold line
        r0 = line_reads;
        for (int i = 0; i < 8; i++) begin
            access(base_b + 32'(2*i), 0, 1, '0, "R4 sequential word", cyc);
            if (i > 0) check(cyc == 1, "R3 sequential hit", cyc, 1);
        end
        check(line_reads == r0 + 1, "R4 one access per line", line_reads - r0, 1);

        // R6: data read in buffered segment goes out, line kept
        r0 = line_reads;
        access(base_b + 32'd4, 0, 0, '0, "R6 data read value", cyc);
        check(line_reads == r0 + 1, "R6 data read uses controller", line_reads - r0, 1);
        access(base_b + 32'd8, 0, 1, '0, "R6 line intact value", cyc);
        check(cyc == 1 && line_reads == r0 + 1, "R6 line intact", cyc, 1);

        // R5: switch segments and back
        r0 = line_reads;
        access(base_a + 32'd0, 0, 1, '0, "R5 other segment", cyc);
        access(base_b + 32'd14, 0, 1, '0, "R5 back again", cyc);
        check(line_reads == r0 + 2, "R5 both miss", line_reads - r0, 2);

        // R7: on-chip region
        r0 = line_reads;
        access(32'h0000_0104, 0, 1, '0, "R7 low fetch value", cyc);
        check(cyc == 2, "R7 low latency", cyc, 2);
        access(32'h0000_0200, 1, 0, 32'hCAFE_F00D, "R7 low write", cyc);
        access(32'h0000_0200, 0, 0, '0, "R7 low readback", cyc);
        check(line_reads == r0, "R7 no controller reads", line_reads - r0, 0);
        access(base_b + 32'd2, 0, 1, '0, "R7 line kept value", cyc);
        check(cyc == 1 && line_reads == r0, "R7 line kept", cyc, 1);

        // R9: write elsewhere keeps line
        access(base_a + 32'd4, 1, 0, 32'h1234_5678, "R9 far write", cyc);
        r0 = line_reads;
        access(base_b + 32'd0, 0, 1, '0, "R9 still hit value", cyc);
        check(cyc == 1 && line_reads == r0, "R9 still hit", cyc, 1);
        access(base_a + 32'd4, 0, 0, '0, "R9 far write landed", cyc);

        // R8: write in buffered segment invalidates
        access(base_b + 32'd12, 1, 0, 32'hDEAD_BEEF, "R8 near write", cyc);
        r0 = line_reads;
        access(base_b + 32'd12, 0, 1, '0, "R8 fresh word", cyc);
        check(line_reads == r0 + 1, "R8 refetch after write", line_reads - r0, 1);
        access(base_b + 32'd6, 0, 1, '0, "R8 refilled hit", cyc);
        check(cyc == 1, "R8 refilled hit zero wait", cyc, 1);

        repeat (3) @(negedge clk);
        check(exp_data.size() == 0, "R2 all reads returned", exp_data.size(), 0);
        finish_run();
    end
endmodule